// File: doc/BRIEF.md
# Column-Strip Scan Controller

This block sequences a streaming 3x3 edge-detection engine across an image held in a row-major buffer. The image is cut into vertical strips whose width equals the number of parallel pixel lanes. Within each strip the controller pulls rows one at a time into the engine's three-row window. It lets the engine compute one output row per window position and writes that row back, then moves to the next strip. It produces a row-shift command for the window, a read offset for the source buffer, a write offset and write enable for the result buffer, and a completion flag.

The source buffer returns data one cycle after the offset appears on `rd_offset`. The offset is itself a register, so the decision to fetch a row is made two cycles before that row is consumed. The controller therefore issues read offsets ahead of the states that shift rows in. At the end of a strip, the controller starts fetching the next strip's first rows while the last output row of the current strip is still being computed. The base offset of the next strip is kept in registers that are bumped once per strip, so the address path has no divide or modulo. The image must have at least four rows. The result for output row r lands at row r of the result buffer, in the columns of its strip.

Top module: `scan_ctrl`

## Requirements
- R1: After reset (synchronous, active low, also when applied mid-run), and while idle with `go` low, `rd_offset` and `wr_offset` are 0 and `shift_rows`, `wr_en` and `done` are 0.
- R2: With `go` high in idle, `done` first rises 1 + S*(2*N-2) cycles later. N is `num_rows`, and S = ceil(`num_cols`/LANES) is the number of strips. A strip is the last one when its first column plus LANES reaches or exceeds `num_cols`.
- R3: `shift_rows` is high for exactly the load cycles: three at the start of each strip, then one before every later compute cycle of that strip. It is never high in a cycle where `wr_en` is high.
- R4: The source buffer returns the word at the offset presented one cycle earlier. At every write cycle for output row r of strip s, the three words most recently shifted in are, oldest first, at offsets s*LANES + r*stride, s*LANES + (r+1)*stride and s*LANES + (r+2)*stride. Each load cycle between compute cycles advances `rd_offset` by one stride.
- R5: Writes are strip-major. Output row r (0 to N-3) of strip s is written at `wr_offset` = s*LANES + r*stride, and each compute cycle that is not the last of its strip advances `wr_offset` by one stride.
- R6: Each strip produces exactly N-2 write cycles, so a run produces S*(N-2) writes.
- R7: `done` stays high while `go` remains high. The cycle after `go` is seen low in that state, the block is idle with `done` low and both offsets 0.
- R8: In the first load cycle of a run, `rd_offset` equals `row_stride`, because the fetch of row 1 was issued in the cycle that accepted `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Start request; must stay high until `done` is seen |
| num_rows | input | ROW_W | Image height in rows (at least 4) |
| num_cols | input | COL_W | Image width in columns |
| row_stride | input | OFF_W | Buffer distance between vertically adjacent pixels |
| shift_rows | output | 1 | Shift the read word into the three-row window |
| rd_offset | output | OFF_W | Source buffer read offset |
| wr_offset | output | OFF_W | Result buffer write offset |
| wr_en | output | 1 | Result buffer write strobe |
| done | output | 1 | Whole image processed |

## Verification
The bench connects the controller to an identity-content buffer model with the stated read latency. At each write, it checks that the three rows in the window are the ones the output row needs. A controller that issues read offsets one cycle late or early would shift in a neighbouring row and fail this check. Jumping to the next strip at the wrong time would show stale rows from the old strip at the first write of the new one. The shapes tested include a four-row image, which has a single compute-then-last pair and no middle load cycles, and a width that does not divide evenly by the lane count, which catches an off-by-one in the last-strip test. Exact write counts and cycle counts expose a missing or repeated load or compute state. The bench also exercises the hold of `done` while `go` stays high, and a reset applied mid-strip, which must leave no leftover offset.

// File: rtl/scan_pkg.sv
// Package: shared state encoding for the column-strip scan controller.
// Assumes nothing beyond a 4-bit state register being sufficient.
package scan_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,      // waiting for go
        ST_FILL0,     // first window row shifting in
        ST_FILL1,     // second window row shifting in
        ST_FILL2,     // third window row shifting in
        ST_CALC,      // compute and write one output row
        ST_STEP,      // shift in next row, more rows follow
        ST_STEP_END,  // shift in final row of strip
        ST_CALC_END,  // compute and write last row of strip
        ST_DONE       // image complete, waiting for go to drop
    } scan_state_e;

endpackage

// File: rtl/scan_fsm.sv
// Module: scan_fsm
// Holds the sequencing state. Per strip: three fill cycles, then compute
// cycles separated by single row-step cycles, ending with a final step and
// a final compute. Assumes last_row / last_strip are valid in the states
// that test them.
module scan_fsm
    import scan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        last_row,
    input  logic        last_strip,
    output scan_state_e state
);

    scan_state_e state_nx;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     state_nx = go ? ST_FILL0 : ST_IDLE;
            ST_FILL0:    state_nx = ST_FILL1;
            ST_FILL1:    state_nx = ST_FILL2;
            ST_FILL2:    state_nx = ST_CALC;
            ST_CALC:     state_nx = last_row ? ST_STEP_END : ST_STEP;
            ST_STEP:     state_nx = ST_CALC;
            ST_STEP_END: state_nx = ST_CALC_END;
            ST_CALC_END: state_nx = last_strip ? ST_DONE : ST_FILL0;
            ST_DONE:     state_nx = go ? ST_DONE : ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/scan_count.sv
// Module: scan_count
// Tracks the window's centre row (starting at 1) and the first column of the
// current strip, and flags the last compute row and the last strip.
// Assumes num_rows >= 4 and that the image size is stable during a run.
module scan_count
    import scan_pkg::*;
#(
    parameter int LANES = 4,
    parameter int ROW_W = 12,
    parameter int COL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  scan_state_e      state,
    input  logic [ROW_W-1:0] num_rows,
    input  logic [COL_W-1:0] num_cols,
    output logic             last_row,
    output logic             last_strip
);

    localparam logic [COL_W:0] LANES_C  = (COL_W+1)'(LANES);
    localparam logic [ROW_W:0] WINDOW_C = (ROW_W+1)'(3);

    logic [ROW_W-1:0] row_cnt;
    logic [COL_W-1:0] col_pos;

    // Row and strip position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_cnt <= ROW_W'(1);
            col_pos <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    row_cnt <= ROW_W'(1);
                    col_pos <= '0;
                end
                ST_CALC:     row_cnt <= row_cnt + ROW_W'(1);
                ST_CALC_END: begin
                    row_cnt <= ROW_W'(1);
                    col_pos <= col_pos + COL_W'(LANES);
                end
                default: ;
            endcase
        end
    end

    // Boundary flags, compared one bit wider to avoid wrap.
    always_comb begin
        last_row   = ({1'b0, row_cnt} + WINDOW_C) >= {1'b0, num_rows};
        last_strip = ({1'b0, col_pos} + LANES_C)  >= {1'b0, num_cols};
    end

endmodule

// File: rtl/scan_addr.sv
// Module: scan_addr
// Generates the source read offset (running ahead of the row loads) and the
// result write offset. The next strip's base offsets are kept in registers
// and advanced once per strip in the first fill cycle, so no division or
// modulo is needed. Assumes row_stride is stable during a run.
module scan_addr
    import scan_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OFF_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  scan_state_e      state,
    input  logic [OFF_W-1:0] row_stride,
    output logic [OFF_W-1:0] rd_offset,
    output logic [OFF_W-1:0] wr_offset
);

    localparam logic [OFF_W-1:0] STRIP_STEP = OFF_W'(LANES);

    logic [OFF_W-1:0] rd_base_nx;
    logic [OFF_W-1:0] wr_base_nx;

    // Read offset: one row ahead of the loads that consume it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_offset <= '0;
        end else begin
            case (state)
                ST_IDLE:     rd_offset <= go ? row_stride : '0;
                ST_FILL0,
                ST_FILL1,
                ST_STEP,
                ST_CALC_END: rd_offset <= rd_offset + row_stride;
                ST_STEP_END: rd_offset <= rd_base_nx;
                ST_DONE:     rd_offset <= '0;
                default:     ;
            endcase
        end
    end

    // Write offset: one row per compute, jump to next strip at strip end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_offset <= '0;
        end else begin
            case (state)
                ST_IDLE,
                ST_DONE:     wr_offset <= '0;
                ST_CALC:     wr_offset <= wr_offset + row_stride;
                ST_CALC_END: wr_offset <= wr_base_nx;
                default:     ;
            endcase
        end
    end

    // Next-strip base registers, advanced once per strip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_base_nx <= '0;
            wr_base_nx <= '0;
        end else if (state == ST_IDLE) begin
            rd_base_nx <= '0;
            wr_base_nx <= '0;
        end else if (state == ST_FILL0) begin
            rd_base_nx <= rd_base_nx + STRIP_STEP;
            wr_base_nx <= wr_base_nx + STRIP_STEP;
        end
    end

endmodule

// File: rtl/scan_ctrl.sv
// Module: scan_ctrl (top)
// Column-strip scan controller for a streaming three-row window engine.
// Assumes a source buffer that returns data one cycle after rd_offset is
// presented, num_rows >= 4, and inputs held stable from go until done.
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int LANES = 4,
    parameter int ROW_W = 12,
    parameter int COL_W = 12,
    parameter int OFF_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [ROW_W-1:0] num_rows,
    input  logic [COL_W-1:0] num_cols,
    input  logic [OFF_W-1:0] row_stride,
    output logic             shift_rows,
    output logic [OFF_W-1:0] rd_offset,
    output logic [OFF_W-1:0] wr_offset,
    output logic             wr_en,
    output logic             done
);

    scan_state_e state;
    logic        last_row;
    logic        last_strip;

    scan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .last_row   (last_row),
        .last_strip (last_strip),
        .state      (state)
    );

    scan_count #(
        .LANES (LANES),
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .num_rows   (num_rows),
        .num_cols   (num_cols),
        .last_row   (last_row),
        .last_strip (last_strip)
    );

    scan_addr #(
        .LANES (LANES),
        .OFF_W (OFF_W)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .state      (state),
        .row_stride (row_stride),
        .rd_offset  (rd_offset),
        .wr_offset  (wr_offset)
    );

    // Output strobes decoded from the registered state.
    always_comb begin
        shift_rows = (state == ST_FILL0) || (state == ST_FILL1) ||
                     (state == ST_FILL2) || (state == ST_STEP)  ||
                     (state == ST_STEP_END);
        wr_en      = (state == ST_CALC) || (state == ST_CALC_END);
        done       = (state == ST_DONE);
    end

endmodule

// File: rtl/scan_ctrl_checker.sv
// Module: scan_ctrl_checker
// Temporal checks on the scan controller, attached by bind below.
// Assumes it sees the top's state register through the bind connection.
module scan_ctrl_checker
    import scan_pkg::*;
#(
    parameter int OFF_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic [OFF_W-1:0] row_stride,
    input scan_state_e      state,
    input logic             shift_rows,
    input logic             wr_en,
    input logic [OFF_W-1:0] rd_offset,
    input logic [OFF_W-1:0] wr_offset,
    input logic             done
);

    // Idle outputs are quiet.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!shift_rows && !wr_en && !done && wr_offset == '0));

    // Loads and writes never coincide.
    assert_no_shift_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_rows && wr_en));

    // A mid-strip step fetches one row further.
    assert_step_prefetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEP) |=> (rd_offset == $past(rd_offset) + $past(row_stride)));

    // A non-final compute moves the write one row down.
    assert_write_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALC) |=> (wr_offset == $past(wr_offset) + $past(row_stride)));

    // Completion holds while go stays high.
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && go) |=> done);

    // Completion releases to a clean idle when go drops.
    assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !go) |=> (!done && rd_offset == '0 && wr_offset == '0));

endmodule

bind scan_ctrl scan_ctrl_checker #(.OFF_W(OFF_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .row_stride (row_stride),
    .state      (state),
    .shift_rows (shift_rows),
    .wr_en      (wr_en),
    .rd_offset  (rd_offset),
    .wr_offset  (wr_offset),
    .done       (done)
);

// File: tb/tb_scan_ctrl.sv
// Bench for scan_ctrl: identity-content source buffer with one-cycle read
// return, a table of image shapes walked by one loop, then directed tests.
module tb_scan_ctrl;

    localparam int LANES = 4;
    localparam int ROW_W = 12;
    localparam int COL_W = 12;
    localparam int OFF_W = 20;

    // rows, cols, stride, expected writes, expected cycles to done
    localparam int NCFG = 4;
    localparam int CFG [NCFG][5] = '{
        '{4,  4, 16,  2,  7},
        '{6,  8,  8,  8, 21},
        '{5, 10, 12,  9, 25},
        '{8, 12, 12, 18, 43}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             go = 1'b0;
    logic [ROW_W-1:0] num_rows = '0;
    logic [COL_W-1:0] num_cols = '0;
    logic [OFF_W-1:0] row_stride = '0;
    logic             shift_rows;
    logic [OFF_W-1:0] rd_offset;
    logic [OFF_W-1:0] wr_offset;
    logic             wr_en;
    logic             done;
    logic [OFF_W-1:0] mem_q = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int win0, win1, win2;

    always #5 clk = ~clk;

    scan_ctrl #(
        .LANES (LANES), .ROW_W (ROW_W), .COL_W (COL_W), .OFF_W (OFF_W)
    ) dut (
        .clk (clk), .rst_n (rst_n), .go (go),
        .num_rows (num_rows), .num_cols (num_cols), .row_stride (row_stride),
        .shift_rows (shift_rows), .rd_offset (rd_offset), .wr_offset (wr_offset),
        .wr_en (wr_en), .done (done)
    );

    // Source buffer model: content equals address, one-cycle return.
    always @(posedge clk) mem_q <= rd_offset;

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        check(rd_offset == 0, {tag, " rd_offset"}, rd_offset, 0);
        check(wr_offset == 0, {tag, " wr_offset"}, wr_offset, 0);
        check({shift_rows, wr_en, done} == 3'b000, {tag, " strobes"},
              {shift_rows, wr_en, done}, 0);
    endtask

    task automatic run_image(input int rows, input int cols, input int stride,
                             input int exp_wr, input int exp_cyc);
        int nwr = 0;
        int ncyc = 0;
        bit first = 1'b1;
        num_rows   = ROW_W'(rows);
        num_cols   = COL_W'(cols);
        row_stride = OFF_W'(stride);
        go = 1'b1;
        while (ncyc < 2000) begin
            @(negedge clk);
            ncyc++;
            if (done) break;
            if (wr_en) begin
                int s = nwr / (rows - 2);
                int r = nwr % (rows - 2);
                int base = s * LANES;
                check(wr_offset == OFF_W'(base + r * stride), "R5 write offset",
                      wr_offset, base + r * stride);
                check(win0 == base + r * stride, "R4 window oldest", win0, base + r * stride);
                check(win1 == base + (r + 1) * stride, "R4 window middle", win1, base + (r + 1) * stride);
                check(win2 == base + (r + 2) * stride, "R4 window newest", win2, base + (r + 2) * stride);
                check(!shift_rows, "R3 shift during write", shift_rows, 0);
                nwr++;
            end
            if (shift_rows) begin
                if (first) begin
                    check(rd_offset == OFF_W'(stride), "R8 first load rd_offset", rd_offset, stride);
                    first = 1'b0;
                end
                win0 = win1;
                win1 = win2;
                win2 = int'(mem_q);
            end
        end
        check(ncyc == exp_cyc, "R2 cycles to done", ncyc, exp_cyc);
        check(nwr == exp_wr, "R6 write count", nwr, exp_wr);
        // R7: done holds while go is high
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(done, "R7 done hold", done, 1);
        end
        go = 1'b0;
        @(negedge clk);
        check_idle("R7 release");
    endtask

    initial begin
        win0 = -1; win1 = -1; win2 = -1;
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        rst_n = 1'b1;
        // R1: idle with go low stays quiet
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check_idle("R1 idle");
        end

        // Table of image shapes.
        for (int i = 0; i < NCFG; i++) begin
            run_image(CFG[i][0], CFG[i][1], CFG[i][2], CFG[i][3], CFG[i][4]);
            @(negedge clk);
        end

        // R1: reset in the middle of a strip.
        num_rows = ROW_W'(8); num_cols = COL_W'(8); row_stride = OFF_W'(8);
        go = 1'b1;
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        go = 1'b0;
        @(negedge clk);
        check_idle("R1 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset release");

        // Clean run after the reset.
        run_image(6, 5, 20, 8, 21);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule